// File: doc/BRIEF.md
# MII Carrier and Collision Controller

This block is the status and nibble-transfer edge of a 10/100 Ethernet PHY facing its MAC. It takes internal indications of transmit activity and receive activity and turns them into the carrier-sense and collision outputs. The rules for both outputs depend on whether the link runs in half or full duplex. A duplex change requested while carrier is up is held back until carrier drops, so the rules never switch in the middle of a frame.

The block makes one nibble clock from a single reference clock through a clock-enable divider. A speed select picks a fast or a slow half-period. That clock drives both the transmit and the receive clock outputs, because the PHY sources both of them. On each rising nibble-clock edge, the transmit nibble and enable from the MAC are captured toward the datapath, and the receive nibble and valid from the datapath are presented to the MAC. There is no transmit-error path.

During power-on reset, two enables are held low: one isolates the MII outputs and one tri-states the line transmitter. Both enables go high together on a clean edge a fixed number of reference cycles after reset is released. This allows the MII to be connected to a MAC that is already powered.

Top module: `mii_status_ctl`

## Requirements
- R1: `tx_clk` and `rx_clk` carry the same waveform, with a half-period of FAST_HALF reference cycles when `speed_100`=1 and SLOW_HALF cycles when it is 0. With the defaults this gives full periods of 4 and 40 reference cycles.
- R2: In half duplex, `crs` is 1 one reference cycle after `tx_act` or `rx_act` is 1, and 0 one cycle after both are 0.
- R3: In half duplex, `col` is 1 one cycle after `tx_act` and `rx_act` are both 1, and 0 otherwise.
- R4: In full duplex, `crs` follows `rx_act` one cycle later, and `tx_act` has no effect on it.
- R5: In full duplex, `col` stays 0 whatever the activity inputs are.
- R6: While `por_n`=0, `mii_oe` and `line_oe` are 0. Both go to 1 after the REL_CYCLES-th (default 4th) rising reference edge that follows the release of reset, and they stay at 1.
- R7: `mac_txd`/`mac_txen` are captured into `dp_txd`/`dp_txen` on each rising nibble-clock edge.
- R8: `dp_rxd`/`dp_rxdv` are presented on `mii_rxd`/`mii_rxdv` on each rising nibble-clock edge, and `mii_rxd` is 0 whenever `mii_rxdv` is 0.
- R9: `full_duplex_req` (1 = full, 0 = half; the duplex mode after reset is half) takes effect only on a cycle when `crs` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| speed_100 | input | 1 | 1 selects the fast nibble clock, 0 the slow one |
| full_duplex_req | input | 1 | Requested duplex: 1 full, 0 half |
| tx_act | input | 1 | Internal transmit activity |
| rx_act | input | 1 | Internal receive activity |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| mac_txen | input | 1 | Transmit enable from the MAC |
| dp_rxd | input | 4 | Receive nibble from the datapath |
| dp_rxdv | input | 1 | Receive valid from the datapath |
| tx_clk | output | 1 | Transmit nibble clock to the MAC |
| rx_clk | output | 1 | Receive nibble clock to the MAC |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| dp_txd | output | 4 | Captured transmit nibble to the datapath |
| dp_txen | output | 1 | Captured transmit enable to the datapath |
| mii_rxd | output | 4 | Receive nibble to the MAC |
| mii_rxdv | output | 1 | Receive valid to the MAC |
| mii_oe | output | 1 | Output enable for the MII outputs |
| line_oe | output | 1 | Output enable for the line transmit drivers |

## Verification
Two things can happen in the same cycle. One is receive activity arriving while a transmission is running, which makes `crs` and `col` rise together. The other is a duplex request that changes while carrier is up, which has to be held back rather than applied. The bench raises `rx_act` during `tx_act` in both duplex modes and checks the `col` rule for each mode. It also flips `full_duplex_req` in the middle of a transmission and checks that transmit-only carrier stays up. After carrier drops, it restarts transmission and checks that the full-duplex rule is now in force.

// File: rtl/mii_status_ctl.sv
module mii_status_ctl #(
  parameter int FAST_HALF  = 2,
  parameter int SLOW_HALF  = 20,
  parameter int REL_CYCLES = 4
) (
  input  logic       clk_ref,
  input  logic       por_n,
  input  logic       speed_100,
  input  logic       full_duplex_req,
  input  logic       tx_act,
  input  logic       rx_act,
  input  logic [3:0] mac_txd,
  input  logic       mac_txen,
  input  logic [3:0] dp_rxd,
  input  logic       dp_rxdv,
  output logic       tx_clk,
  output logic       rx_clk,
  output logic       crs,
  output logic       col,
  output logic [3:0] dp_txd,
  output logic       dp_txen,
  output logic [3:0] mii_rxd,
  output logic       mii_rxdv,
  output logic       mii_oe,
  output logic       line_oe
);
  localparam int DW = $clog2(SLOW_HALF + 1);
  localparam int RW = $clog2(REL_CYCLES + 1);
  localparam logic [DW-1:0] FAST_LIM = DW'(FAST_HALF - 1);
  localparam logic [DW-1:0] SLOW_LIM = DW'(SLOW_HALF - 1);
  localparam logic [RW-1:0] REL_LAST = RW'(REL_CYCLES - 1);
  localparam logic [RW-1:0] REL_DONE = RW'(REL_CYCLES);

  logic [DW-1:0] div_cnt;
  logic          nib_clk, half_end, nib_rise;
  logic [RW-1:0] rel_cnt;
  logic          en_q, fd_q;

  assign half_end = div_cnt >= (speed_100 ? FAST_LIM : SLOW_LIM);
  assign nib_rise = half_end && !nib_clk;
  assign tx_clk   = nib_clk;
  assign rx_clk   = nib_clk;
  assign mii_oe   = en_q;
  assign line_oe  = en_q;

  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n) begin
      div_cnt <= '0;
      nib_clk <= 1'b0;
    end else if (half_end) begin
      div_cnt <= '0;
      nib_clk <= !nib_clk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end

  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n) begin
      rel_cnt <= '0;
      en_q    <= 1'b0;
    end else begin
      if (rel_cnt != REL_DONE) rel_cnt <= rel_cnt + 1'b1;
      if (rel_cnt == REL_LAST) en_q <= 1'b1;
    end

  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n) begin
      fd_q <= 1'b0;
      crs  <= 1'b0;
      col  <= 1'b0;
    end else begin
      if (!crs) fd_q <= full_duplex_req;
      crs <= fd_q ? rx_act : (tx_act | rx_act);
      col <= !fd_q && tx_act && rx_act;
    end

  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n) begin
      dp_txd   <= '0;
      dp_txen  <= 1'b0;
      mii_rxd  <= '0;
      mii_rxdv <= 1'b0;
    end else if (nib_rise) begin
      dp_txd   <= mac_txd;
      dp_txen  <= mac_txen;
      mii_rxd  <= dp_rxdv ? dp_rxd : 4'h0;
      mii_rxdv <= dp_rxdv;
    end

  assert_clk_pair_R1: assert property (@(posedge clk_ref) disable iff (!por_n)
    tx_clk == rx_clk);
  assert_half_crs_R2: assert property (@(posedge clk_ref) disable iff (!por_n)
    (!$past(fd_q) && ($past(tx_act) || $past(rx_act))) |-> crs);
  assert_half_col_R3: assert property (@(posedge clk_ref) disable iff (!por_n)
    (!$past(fd_q) && $past(tx_act) && $past(rx_act)) |-> col);
  assert_full_crs_R4: assert property (@(posedge clk_ref) disable iff (!por_n)
    $past(fd_q) |-> (crs == $past(rx_act)));
  assert_full_col_R5: assert property (@(posedge clk_ref) disable iff (!por_n)
    ($past(fd_q) && fd_q) |-> !col);
  assert_oe_sticky_R6: assert property (@(posedge clk_ref) disable iff (!por_n)
    mii_oe |=> (mii_oe && line_oe));
  assert_oe_timing_R6: assert property (@(posedge clk_ref) disable iff (!por_n)
    $rose(mii_oe) |-> (rel_cnt == REL_DONE));
  assert_rxd_zero_R8: assert property (@(posedge clk_ref) disable iff (!por_n)
    !mii_rxdv |-> (mii_rxd == 4'h0));
  assert_duplex_idle_R9: assert property (@(posedge clk_ref) disable iff (!por_n)
    !$stable(fd_q) |-> !$past(crs));
endmodule

// File: tb/sim_mii_status_ctl.sv
module sim_mii_status_ctl;
  logic clk_ref = 1'b0, por_n = 1'b0, speed_100 = 1'b1, full_duplex_req = 1'b0;
  logic tx_act = 1'b0, rx_act = 1'b0, mac_txen = 1'b0, dp_rxdv = 1'b0;
  logic [3:0] mac_txd = 4'h0, dp_rxd = 4'h0;
  logic tx_clk, rx_clk, crs, col, dp_txen, mii_rxdv, mii_oe, line_oe;
  logic [3:0] dp_txd, mii_rxd;

  int checks = 0, fails = 0;
  int    q_sel[$];
  int    q_exp[$];
  string q_req[$];

  always #2 clk_ref = !clk_ref;

  mii_status_ctl u0 (.*);

  function automatic int observe(int sel);
    case (sel)
      0: return int'(crs);
      1: return int'(col);
      2: return int'(mii_oe);
      3: return int'(line_oe);
      4: return int'(dp_txd);
      5: return int'(dp_txen);
      6: return int'(mii_rxd);
      7: return int'(mii_rxdv);
      default: return int'(tx_clk == rx_clk);
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_next(int sel, int exp, string req);
    q_sel.push_back(sel);
    q_exp.push_back(exp);
    q_req.push_back(req);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
  endtask

  initial forever begin
    @(posedge clk_ref);
    #1;
    while (q_sel.size() > 0) begin
      int s, e;
      string r;
      s = q_sel.pop_front();
      e = q_exp.pop_front();
      r = q_req.pop_front();
      check(r, observe(s), e);
    end
  end

  task automatic set_act(logic t, logic r);
    tx_act = t;
    rx_act = r;
  endtask

  task automatic measure_period(int exp, string req);
    int n = 0;
    logic prev;
    prev = tx_clk;
    while (!(prev == 1'b0 && tx_clk == 1'b1)) begin prev = tx_clk; step(1); end
    prev = tx_clk;
    step(1);
    n = 1;
    while (!(prev == 1'b0 && tx_clk == 1'b1)) begin prev = tx_clk; step(1); n++; end
    check(req, n, exp);
    check(req, int'(tx_clk == rx_clk), 1);
  endtask

  task automatic run_tests;
    step(2);
    expect_next(2, 0, "R6 mii_oe in reset");
    expect_next(3, 0, "R6 line_oe in reset");
    expect_next(0, 0, "R2 crs in reset");
    step(1);
    por_n = 1'b1;
    step(2);
    expect_next(2, 0, "R6 mii_oe before release");
    step(1);
    expect_next(2, 1, "R6 mii_oe released");
    expect_next(3, 1, "R6 line_oe released");
    step(1);
    step(5);
    expect_next(2, 1, "R6 mii_oe held");
    step(1);
    // half duplex rules
    set_act(1, 0); expect_next(0, 1, "R2 tx only"); expect_next(1, 0, "R3 tx only"); step(1);
    set_act(0, 1); expect_next(0, 1, "R2 rx only"); expect_next(1, 0, "R3 rx only"); step(1);
    set_act(1, 1); expect_next(0, 1, "R2 both");    expect_next(1, 1, "R3 collision"); step(1);
    set_act(0, 0); expect_next(0, 0, "R2 idle");    expect_next(1, 0, "R3 idle"); step(1);
    // full duplex rules
    full_duplex_req = 1'b1; step(3);
    set_act(1, 0); expect_next(0, 0, "R4 tx ignored"); expect_next(1, 0, "R5 tx only"); step(1);
    set_act(0, 1); expect_next(0, 1, "R4 rx carrier"); step(1);
    set_act(1, 1); expect_next(0, 1, "R4 both");    expect_next(1, 0, "R5 no collision"); step(1);
    set_act(0, 0); expect_next(0, 0, "R4 idle"); step(1);
    // deferred duplex change
    full_duplex_req = 1'b0; step(3);
    set_act(1, 0); step(2);
    full_duplex_req = 1'b1; step(3);
    expect_next(0, 1, "R9 change held while carrier up"); step(1);
    set_act(0, 0); step(2);
    set_act(1, 0); expect_next(0, 0, "R9 full duplex after idle"); step(1);
    set_act(0, 0); step(2);
    // transmit and receive nibbles, fast clock
    mac_txd = 4'hA; mac_txen = 1'b1; dp_rxd = 4'hC; dp_rxdv = 1'b1; step(12);
    expect_next(4, 10, "R7 txd fast"); expect_next(5, 1, "R7 txen fast");
    expect_next(6, 12, "R8 rxd fast"); expect_next(7, 1, "R8 rxdv fast"); step(1);
    mac_txd = 4'h5; mac_txen = 1'b0; dp_rxd = 4'h3; dp_rxdv = 1'b0; step(12);
    expect_next(4, 5, "R7 txd idle"); expect_next(5, 0, "R7 txen low");
    expect_next(6, 0, "R8 rxd zero without valid"); expect_next(7, 0, "R8 rxdv low"); step(1);
    measure_period(4, "R1 fast period");
    // slow clock
    speed_100 = 1'b0; step(50);
    measure_period(40, "R1 slow period");
    mac_txd = 4'h6; mac_txen = 1'b1; dp_rxd = 4'h9; dp_rxdv = 1'b1; step(90);
    expect_next(4, 6, "R7 txd slow"); expect_next(6, 9, "R8 rxd slow"); step(2);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk_ref);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule